// File: doc/BRIEF.md
# Two-Level Six-Source Interrupt Arbiter

This block collects six interrupt sources: two external pins (active low), three timer sources and one serial source. It gates them with an enable register and splits them between two priority levels using a priority register. Every cycle it presents the CPU with one request and a 3-bit vector index. When the CPU accepts the request by pulsing `ack`, the block records the level of the accepted source as in service. A return strobe `reti` ends the handler.

A high-level request can preempt a low-level handler. No request can interrupt a handler running at its own level or at a higher level. Each external input can be set to level-sensitive or falling-edge mode.

Timer 0 and timer 1 flags are polled one cycle after they appear. When one of them is accepted, the block returns a one-cycle clear strobe for it. The third timer's request is the OR of its overflow flag and its external flag. The serial request is the OR of the transmit and receive flags. These two sources are polled in the cycle they are raised, and the block never clears them. Each clock cycle stands for one machine cycle.

Top module: `irq_arbiter6`

## Requirements
- R1: After reset the enable register reads 0x00, the priority register reads 0x00, `irq_req` is 0 and `inserv` is 00.
- R2: Source index order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5. Enable bit k enables source k for k in 0..5. Bit 7 is the global enable. Bit 6 is reserved: it reads 0 and ignores writes.
- R3: While enable bit 7 is 0, `irq_req` stays 0 whatever is pending. While it is 1, a pending source requests only if its own enable bit is 1.
- R4: Priority bit k set to 1 puts source k on the high level. Any enabled high-level request wins over every low-level request.
- R5: Within one level, the lowest source index wins. `irq_vec` carries that index.
- R6: A timer 0 or timer 1 flag raised in cycle N can first request in cycle N+1. Timer 2 and serial requests appear in the same cycle their inputs rise.
- R7: The serial request is `ser_tx | ser_rx`. The timer 2 request is `t2_ovf | t2_ext`.
- R8: In edge mode (`ext_edge[i]`=1), a flag is latched when the pin is sampled 1 in one cycle and 0 in the next. The flag persists after the pin returns high and is cleared when that source is acknowledged. In level mode the source requests while the previous cycle's pin sample is 0.
- R9: Acknowledging timer 0 or timer 1 raises `clr_t0` or `clr_t1` for exactly that cycle. Acknowledging any other source raises neither strobe and leaves the timer 2 and serial flags pending.
- R10: `ack` while `irq_req` is 1 sets the in-service bit of the granted level (`inserv[1]` high, `inserv[0]` low). Requests of equal or lower level are blocked while that bit is set, but a high request may preempt a low handler.
- R11: `reti` clears the highest set in-service bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 6 | Priority register write data |
| pri_rdata | output | 6 | Priority register contents |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per pin: 1 selects falling-edge mode, 0 level mode |
| t0_flag | input | 1 | Timer 0 overflow flag |
| t1_flag | input | 1 | Timer 1 overflow flag |
| t2_ovf | input | 1 | Timer 2 overflow flag |
| t2_ext | input | 1 | Timer 2 external flag |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 3 | Index of the winning source |
| clr_t0 | output | 1 | Clear strobe for the timer 0 flag |
| clr_t1 | output | 1 | Clear strobe for the timer 1 flag |
| inserv | output | 2 | In-service bits, [1] high level, [0] low level |

## Verification
The assertions check the following on every cycle:
- the global-enable gate and that no request appears while a high handler runs;
- that the reserved enable bit stays zero and the clear strobes only appear with an accepted timer 0 or timer 1 grant;
- that an edge flag latches after a sampled fall;
- how `reti` moves the in-service bits.

Only the bench scenarios can show the following:
- the choice of winner across levels and poll order, which is swept over every pending and priority pattern;
- the one-cycle polling lag of timer 0 and timer 1 against timer 2 and serial;
- that the timer 2 and serial flags survive an acknowledge and request again after the return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 6;
  localparam int VEC_W = $clog2(NSRC);
  localparam int NEXT  = 2;
  localparam int EN_W  = 8;
  localparam int GLB_BIT = EN_W - 1;
  localparam int RSV_BIT = EN_W - 2;

  localparam int SRC_EXT0 = 0;
  localparam int SRC_T0   = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_T1   = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_T2   = 5;

  typedef logic [NSRC-1:0] src_vec_t;

  // Lowest set index of a source vector; 0 when empty.
  function automatic logic [VEC_W-1:0] first_idx(input src_vec_t v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) idx = VEC_W'(i);
    end
    return idx;
  endfunction

  // Per-source enable mask after applying the global bit.
  function automatic src_vec_t gate_mask(input logic [EN_W-1:0] en);
    return en[GLB_BIT] ? en[NSRC-1:0] : '0;
  endfunction

  // Value stored for an enable write: the reserved bit is dropped.
  function automatic logic [EN_W-1:0] en_store(input logic [EN_W-1:0] w);
    logic [EN_W-1:0] r;
    r = w;
    r[RSV_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic samp_q;
  logic flag_q;
  logic fall_seen;

  assign fall_seen = samp_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      samp_q <= pin_n;
      if (!edge_mode) flag_q <= 1'b0;
      else            flag_q <= fall_seen | (flag_q & ~clr);
    end
  end

  assign req = edge_mode ? flag_q : ~samp_q;

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall_seen) |=> (flag_q || !edge_mode)); // R8
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
(
  input  src_vec_t         pend_g,
  input  src_vec_t         pri,
  input  logic [1:0]       act,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic             lvl
);
  src_vec_t hi_set;
  src_vec_t lo_set;
  logic     hi_ok;
  logic     lo_ok;

  assign hi_set = pend_g & pri;
  assign lo_set = pend_g & ~pri;
  assign hi_ok  = !act[1] && (hi_set != '0);
  assign lo_ok  = (act == 2'b00) && (lo_set != '0);

  always_comb begin
    req = hi_ok | lo_ok;
    lvl = hi_ok;
    if (hi_ok)      vec = first_idx(hi_set);
    else if (lo_ok) vec = first_idx(lo_set);
    else            vec = '0;
  end

  always_comb begin
    if (req) AST_VEC_RANGE: assert (int'(vec) < NSRC); // R5
  end
endmodule

// File: rtl/irq_inserv.sv
module irq_inserv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       reti,
  output logic [1:0] act
);
  logic [1:0] drop;
  logic [1:0] add;

  always_comb begin
    drop = 2'b00;
    if (reti) begin
      if (act[1])      drop = 2'b10;
      else if (act[0]) drop = 2'b01;
    end
    add = 2'b00;
    if (take) add[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= 2'b00;
    else        act <= (act & ~drop) | add;
  end

  AST_RETI_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && act[1] && !take) |=> (!act[1] && act[0] == $past(act[0]))); // R11
  AST_RETI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && act == 2'b01 && !take) |=> (act == 2'b00)); // R11
endmodule

// File: rtl/irq_arbiter6.sv
module irq_arbiter6
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic [EN_W-1:0]   en_wdata,
  output logic [EN_W-1:0]   en_rdata,
  input  logic              pri_we,
  input  logic [NSRC-1:0]   pri_wdata,
  output logic [NSRC-1:0]   pri_rdata,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [NEXT-1:0]   ext_edge,
  input  logic              t0_flag,
  input  logic              t1_flag,
  input  logic              t2_ovf,
  input  logic              t2_ext,
  input  logic              ser_tx,
  input  logic              ser_rx,
  input  logic              ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              clr_t0,
  output logic              clr_t1,
  output logic [1:0]        inserv
);
  logic [EN_W-1:0] en_q;
  src_vec_t        pri_q;
  logic            t0_poll_q;
  logic            t1_poll_q;
  logic [NEXT-1:0] ext_req;
  logic [NEXT-1:0] ext_clr;
  src_vec_t        pend;
  src_vec_t        pend_g;
  logic            grant;
  logic            grant_lvl;

  assign grant = ack & irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_store(en_wdata);
      if (pri_we) pri_q <= pri_wdata;
    end
  end

  assign en_rdata  = en_q;
  assign pri_rdata = pri_q;

  // Timer 0/1 flags are seen one cycle late; a clear strobe masks the stale copy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_poll_q <= 1'b0;
      t1_poll_q <= 1'b0;
    end else begin
      t0_poll_q <= t0_flag & ~clr_t0;
      t1_poll_q <= t1_flag & ~clr_t1;
    end
  end

  localparam int EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_clr[g] = grant && (irq_vec == VEC_W'(EXT_IDX[g]));
    irq_ext_cond i_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[g]),
      .edge_mode (ext_edge[g]),
      .clr       (ext_clr[g]),
      .req       (ext_req[g])
    );
  end

  always_comb begin
    pend           = '0;
    pend[SRC_EXT0] = ext_req[0];
    pend[SRC_T0]   = t0_poll_q;
    pend[SRC_EXT1] = ext_req[1];
    pend[SRC_T1]   = t1_poll_q;
    pend[SRC_SER]  = ser_tx | ser_rx;
    pend[SRC_T2]   = t2_ovf | t2_ext;
  end

  assign pend_g = pend & gate_mask(en_q);

  irq_arb i_arb (
    .pend_g (pend_g),
    .pri    (pri_q),
    .act    (inserv),
    .req    (irq_req),
    .vec    (irq_vec),
    .lvl    (grant_lvl)
  );

  irq_inserv i_inserv (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (grant),
    .take_lvl (grant_lvl),
    .reti     (reti),
    .act      (inserv)
  );

  assign clr_t0 = grant && (irq_vec == VEC_W'(SRC_T0));
  assign clr_t1 = grant && (irq_vec == VEC_W'(SRC_T1));

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[GLB_BIT] |-> !irq_req); // R3
  AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    inserv[1] |-> !irq_req); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rdata[RSV_BIT]); // R2
  AST_CLR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t0 || clr_t1) |-> (ack && irq_req)); // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_t0, clr_t1})); // R9
  AST_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (inserv != 2'b00)); // R10
endmodule

// File: tb/test_irq_arbiter6.sv
module test_irq_arbiter6;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic       pri_we = 1'b0;
  logic [5:0] pri_wdata = '0;
  logic [5:0] pri_rdata;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] ext_edge = 2'b00;
  logic       t0_flag = 1'b0, t1_flag = 1'b0, t2_ovf = 1'b0, t2_ext = 1'b0;
  logic       ser_tx = 1'b0, ser_rx = 1'b0;
  logic       ack = 1'b0, reti = 1'b0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       clr_t0, clr_t1;
  logic [1:0] inserv;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter6 i_irq_arbiter6 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic at_sample();
    @(negedge clk);
  endtask

  // Pending pattern bit k -> source k stimulus (ext pins level mode, active low).
  task automatic drive_pend(input logic [5:0] p);
    ext_n[0] = ~p[0];
    t0_flag  = p[1];
    ext_n[1] = ~p[2];
    t1_flag  = p[3];
    ser_rx   = p[4];
    t2_ovf   = p[5];
  endtask

  // Reference winner: scan from the high level down, then by ascending index.
  function automatic int model(input logic [5:0] p, input logic [7:0] en,
                               input logic [5:0] pr, input logic [1:0] act);
    int win;
    win = -1;
    if (en[7]) begin
      for (int lv = 1; lv >= 0 && win < 0; lv--) begin
        if ((int'(act) >> lv) == 0) begin
          for (int s = 0; s < 6 && win < 0; s++)
            if (p[s] && en[s] && (pr[s] == lv[0])) win = s;
        end
      end
    end
    return win;
  endfunction

  task automatic wr_en(input logic [7:0] v);
    en_wdata = v; en_we = 1'b1; tick(); en_we = 1'b0;
  endtask

  task automatic wr_pri(input logic [5:0] v);
    pri_wdata = v; pri_we = 1'b1; tick(); pri_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    at_sample();
    chk("R1 en", en_rdata, 0);
    chk("R1 pri", pri_rdata, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 inserv", inserv, 0);
    tick();

    wr_en(8'hFF);
    at_sample();
    chk("R2 reserved bit", en_rdata, 8'hBF);
    tick();

    // R4 R5: sweep every pending pattern against every priority pattern
    for (int pr = 0; pr < 64; pr++) begin
      wr_pri(6'(pr));
      for (int p = 0; p < 64; p++) begin
        drive_pend(6'(p));
        tick();
        at_sample();
        w = model(6'(p), 8'hBF, 6'(pr), 2'b00);
        chk("R4 R5 req", irq_req, w >= 0);
        if (w >= 0) chk("R4 R5 vec", irq_vec, w);
        tick();
      end
    end

    // R2 R3: sweep enable register with all sources pending, mixed priority
    wr_pri(6'b100100);
    drive_pend(6'h3F);
    for (int e = 0; e < 256; e++) begin
      wr_en(8'(e));
      at_sample();
      w = model(6'h3F, 8'(e) & 8'hBF, 6'b100100, 2'b00);
      chk("R2 R3 gate req", irq_req, w >= 0);
      if (w >= 0) chk("R2 R3 gate vec", irq_vec, w);
      tick();
    end
    drive_pend(6'h00);
    wr_pri(6'h00);
    wr_en(8'hBF);
    tick();

    // R6: timer0 lag versus timer2 immediate
    wr_en(8'h82);
    t0_flag = 1'b1;
    at_sample();
    chk("R6 t0 not yet", irq_req, 0);
    tick(); at_sample();
    chk("R6 t0 next cycle", irq_req, 1);
    chk("R6 t0 vec", irq_vec, 1);
    // R9: ack timer0 -> clear strobe in that cycle
    tick();
    ack = 1'b1;
    at_sample();
    chk("R9 clr_t0", clr_t0, 1);
    chk("R9 clr_t1 quiet", clr_t1, 0);
    tick(); ack = 1'b0; t0_flag = 1'b0;
    at_sample();
    chk("R10 low in service", inserv, 1);
    chk("R9 strobe ends", clr_t0, 0);
    tick(); reti = 1'b1; tick(); reti = 1'b0;
    at_sample();
    chk("R11 reti low", inserv, 0);
    chk("R9 t0 consumed", irq_req, 0);
    tick();

    wr_en(8'hA0);
    t2_ovf = 1'b1;
    at_sample();
    chk("R6 t2 same cycle", irq_req, 1);
    chk("R6 t2 vec", irq_vec, 5);
    t2_ovf = 1'b0; t2_ext = 1'b1;
    #1 chk("R7 t2 ext", irq_req, 1);
    tick(); ack = 1'b1;
    at_sample();
    chk("R9 t2 no strobe", {clr_t0, clr_t1}, 0);
    tick(); ack = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
    at_sample();
    chk("R9 t2 still pending", irq_req, 1);
    t2_ext = 1'b0;
    tick();

    wr_en(8'h90);
    ser_tx = 1'b1;
    at_sample();
    chk("R7 serial tx", irq_vec, 4);
    ser_tx = 1'b0; ser_rx = 1'b1;
    #1 chk("R7 serial rx", irq_req, 1);
    ser_rx = 1'b0;
    #1 chk("R7 serial idle", irq_req, 0);
    tick();

    // R8: edge mode on ext0
    wr_en(8'h81);
    ext_edge = 2'b01;
    ext_n[0] = 1'b1; tick(); tick();
    ext_n[0] = 1'b0;
    at_sample();
    chk("R8 before edge sampled", irq_req, 0);
    tick(); at_sample();
    chk("R8 edge latched", irq_req, 1);
    ext_n[0] = 1'b1;
    tick(); at_sample();
    chk("R8 flag persists", irq_req, 1);
    tick(); ack = 1'b1; tick(); ack = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
    at_sample();
    chk("R8 cleared by ack", irq_req, 0);
    tick();
    ext_edge = 2'b00;
    ext_n[0] = 1'b0;
    tick(); at_sample();
    chk("R8 level low", irq_req, 1);
    ext_n[0] = 1'b1;
    tick(); at_sample();
    chk("R8 level released", irq_req, 0);
    tick();

    // R10: preemption rules. t1 low, t2 low, ext0 high.
    wr_en(8'hA9);
    wr_pri(6'b000001);
    t1_flag = 1'b1; t2_ovf = 1'b1;
    tick(); at_sample();
    chk("R5 t1 before t2", irq_vec, 3);
    tick(); ack = 1'b1;
    at_sample();
    chk("R9 clr_t1", clr_t1, 1);
    tick(); ack = 1'b0; t1_flag = 1'b0;
    at_sample();
    chk("R10 low blocks low", irq_req, 0);
    ext_n[0] = 1'b0;
    tick(); at_sample();
    chk("R10 high preempts", irq_req, 1);
    chk("R10 high vec", irq_vec, 0);
    tick(); ack = 1'b1; tick(); ack = 1'b0;
    at_sample();
    chk("R10 both in service", inserv, 3);
    chk("R10 high blocks all", irq_req, 0);
    tick(); reti = 1'b1; tick(); reti = 1'b0;
    at_sample();
    chk("R11 clears high only", inserv, 1);
    chk("R10 high again under low", irq_req, 1);
    ext_n[0] = 1'b1;
    tick(); at_sample();
    chk("R10 t2 still blocked", irq_req, 0);
    tick(); reti = 1'b1; tick(); reti = 1'b0;
    at_sample();
    chk("R11 clears low", inserv, 0);
    chk("R10 t2 resumes", irq_vec, 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule